// File: doc/BRIEF.md
# Integer Multiply and Divide Execute Unit

This block is the integer multiply and divide stage of a 64-bit load/store datapath. Each operation writes one general register directly; there is no hidden product or quotient pair. The issuing logic presents two source operands, a two-bit operation class (word or doubleword, multiply or divide), a five-bit sub-operation code and a destination index, then pulses a start strobe for one cycle. The unit answers with a done pulse, a write-enable, the destination index and the result. A sub-operation code outside the defined pair raises an illegal-operation flag instead.

Multiplication is a single-cycle signed array. The sub-operation code picks the low or high half of the full product. Division is a radix-2 restoring sequencer that works on operand magnitudes and retires one quotient bit per clock. The sub-operation code picks the quotient or the remainder. Word operations use only the low halves of the sources and sign-extend their result. Dividing the most negative value by -1 and dividing by zero both have defined outcomes. While a divide is running, a busy output is high and the unit takes no new start.

Top module: `muldiv_unit`

## Requirements
- R1: With a doubleword multiply (class 1) and sub-operation 2, the result is bits XLEN-1:0 of the signed 2*XLEN-bit product of the two sources.
- R2: With a doubleword multiply and sub-operation 3, the result is bits 2*XLEN-1:XLEN of that signed product.
- R3: A word multiply (class 0) forms the signed product of the two low source halves. Sub-operation 2 returns the product's low half and sub-operation 3 returns its high half, each sign-extended to XLEN. The upper source halves have no effect on the result.
- R4: A doubleword divide (class 3) with sub-operation 2 writes the signed quotient, truncated toward zero.
- R5: A doubleword divide with sub-operation 3 writes the remainder, which carries the sign of the dividend.
- R6: A word divide (class 2) divides the signed low halves of the sources. The quotient or remainder is sign-extended from bit XLEN/2-1, and the upper source halves have no effect.
- R7: When the dividend is the most negative value of the operation width and the divisor is -1, the quotient is that most negative value and the remainder is 0.
- R8: A divide whose divisor (the low half for word class) is zero gives a done pulse one cycle after start, with write-enable low and the illegal flag low.
- R9: A sub-operation code other than 2 or 3, in any class, gives a done pulse together with the illegal flag one cycle after start, with write-enable low.
- R10: A legal multiply gives done and write-enable in the cycle after start, with the destination index of that start on the write-destination output.
- R11: A legal divide with a non-zero divisor holds busy high from the cycle after start. It raises done with write-enable exactly N+2 cycles after the start edge, where N is XLEN/2 for word class and XLEN for doubleword class. Busy is low in the done cycle.
- R12: A start that arrives while busy is high is ignored. It raises no illegal flag, gives no extra done pulse and does not change the result or destination of the divide in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| op_class_i | input | 2 | 0 word multiply, 1 doubleword multiply, 2 word divide, 3 doubleword divide |
| sub_op_i | input | 5 | 2 selects low half or quotient, 3 selects high half or remainder |
| src_a_i | input | XLEN | First operand (multiplicand or dividend) |
| src_b_i | input | XLEN | Second operand (multiplier or divisor) |
| dest_i | input | DEST_W | Destination register index |
| result_o | output | XLEN | Value to write |
| wr_en_o | output | 1 | Write the result this cycle |
| wr_dest_o | output | DEST_W | Destination index for the write |
| done_o | output | 1 | Operation completed this cycle |
| illegal_o | output | 1 | Sub-operation code was not supported |
| busy_o | output | 1 | A divide is in progress; starts are ignored |

## Verification
The assertions assume that rst_n is held low through the first clock edge, and that start_i and the operation fields are known whenever start_i is sampled high. They also assume that a start seen while busy is high has no effect, so a run of starts during a divide may use any field values. The bench changes all inputs just after a falling edge and holds them across the next rising edge. Start stays high for only one cycle, except in the busy test, where it is held for a few cycles that lie wholly inside a divide.

// File: rtl/muldiv_pkg.sv
// Shared encodings for the multiply/divide unit.
// Assumes a two-bit class field and a five-bit sub-operation field.
package muldiv_pkg;
    typedef enum logic [1:0] {
        CLS_MUL_WORD = 2'd0,
        CLS_MUL_DBL  = 2'd1,
        CLS_DIV_WORD = 2'd2,
        CLS_DIV_DBL  = 2'd3
    } op_class_e;

    localparam int          SUBOP_W = 5;
    localparam logic [SUBOP_W-1:0] SUB_LOW  = 5'd2;  // low half / quotient
    localparam logic [SUBOP_W-1:0] SUB_HIGH = 5'd3;  // high half / remainder

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/muldiv_mul.sv
// Single-cycle signed multiplier with half selection.
// Assumes XLEN is even; word mode uses the low XLEN/2 bits of each source.
// Purely combinational; the caller registers the result.
module muldiv_mul #(
    parameter int XLEN = 64
) (
    input  logic            is_word_i,
    input  logic            want_hi_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [PW-1:0]   prod;
    logic [HALF-1:0] word_pick;

    // Pick operand width: sign-extend low halves in word mode.
    always_comb begin
        if (is_word_i) begin
            op_a = {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
            op_b = {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
        end else begin
            op_a = a_i;
            op_b = b_i;
        end
    end

    // Full-width product of sign-extended operands equals the signed product.
    assign prod = {{XLEN{op_a[XLEN-1]}}, op_a} * {{XLEN{op_b[XLEN-1]}}, op_b};

    // Select the requested half and sign-extend word results.
    always_comb begin
        word_pick = want_hi_i ? prod[XLEN-1:HALF] : prod[HALF-1:0];
        if (is_word_i)
            res_o = {{HALF{word_pick[HALF-1]}}, word_pick};
        else
            res_o = want_hi_i ? prod[PW-1:XLEN] : prod[XLEN-1:0];
    end
endmodule

// File: rtl/muldiv_div.sv
// Radix-2 restoring signed divider, one quotient bit per clock.
// Assumes the divisor is non-zero (the caller filters zero divisors) and that
// start_i is only raised while busy_o is low. Word mode runs XLEN/2 steps.
// fin_o is high for one cycle with res_o valid.
module muldiv_div #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            is_word_i,
    input  logic            want_rem_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            busy_o,
    output logic            fin_o,
    output logic [XLEN-1:0] res_o
);
    import muldiv_pkg::*;

    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN + 1);

    div_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [XLEN-1:0]  rem;
    logic [XLEN-1:0]  quo;
    logic [XLEN-1:0]  dvs;
    logic             neg_q;
    logic             neg_r;
    logic             word_q;
    logic             rem_q;

    logic [XLEN-1:0]  op_a;
    logic [XLEN-1:0]  op_b;
    logic [XLEN-1:0]  mag_a;
    logic [XLEN-1:0]  mag_b;
    logic [XLEN:0]    shifted;
    logic [XLEN:0]    diff;
    logic [XLEN-1:0]  pick;

    // Operand preparation: width select and absolute values.
    always_comb begin
        if (is_word_i) begin
            op_a = {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
            op_b = {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
        end else begin
            op_a = a_i;
            op_b = b_i;
        end
        mag_a = op_a[XLEN-1] ? (XLEN'(0) - op_a) : op_a;
        mag_b = op_b[XLEN-1] ? (XLEN'(0) - op_b) : op_b;
    end

    // One restoring step: shift in next dividend bit, trial subtract.
    assign shifted = {rem, quo[XLEN-1]};
    assign diff    = shifted - {1'b0, dvs};

    // Sequencer: load, iterate, present result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DV_IDLE;
            cnt    <= '0;
            rem    <= '0;
            quo    <= '0;
            dvs    <= '0;
            neg_q  <= 1'b0;
            neg_r  <= 1'b0;
            word_q <= 1'b0;
            rem_q  <= 1'b0;
        end else begin
            case (state)
                DV_IDLE: begin
                    if (start_i) begin
                        rem    <= '0;
                        quo    <= is_word_i ? (mag_a << HALF) : mag_a;
                        dvs    <= mag_b;
                        cnt    <= is_word_i ? CNT_W'(HALF) : CNT_W'(XLEN);
                        neg_q  <= op_a[XLEN-1] ^ op_b[XLEN-1];
                        neg_r  <= op_a[XLEN-1];
                        word_q <= is_word_i;
                        rem_q  <= want_rem_i;
                        state  <= DV_RUN;
                    end
                end
                DV_RUN: begin
                    if (!diff[XLEN]) begin
                        rem <= diff[XLEN-1:0];
                        quo <= {quo[XLEN-2:0], 1'b1};
                    end else begin
                        rem <= shifted[XLEN-1:0];
                        quo <= {quo[XLEN-2:0], 1'b0};
                    end
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1))
                        state <= DV_FIN;
                end
                DV_FIN:  state <= DV_IDLE;
                default: state <= DV_IDLE;
            endcase
        end
    end

    // Sign correction and word sign-extension of the chosen value.
    always_comb begin
        if (rem_q)
            pick = neg_r ? (XLEN'(0) - rem) : rem;
        else
            pick = neg_q ? (XLEN'(0) - quo) : quo;
        res_o = word_q ? {{HALF{pick[HALF-1]}}, pick[HALF-1:0]} : pick;
    end

    assign busy_o = (state != DV_IDLE);
    assign fin_o  = (state == DV_FIN);
endmodule

// File: rtl/muldiv_unit.sv
// Integer multiply/divide execute unit, register-direct results.
// Decodes the class and sub-operation, routes multiplies to a one-cycle
// array and divides to the iterative sequencer, and registers the outputs.
// Assumes inputs are valid whenever start_i is high; starts seen while
// busy_o is high are dropped.
module muldiv_unit #(
    parameter int XLEN   = 64,
    parameter int DEST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_class_i,
    input  logic [4:0]        sub_op_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    input  logic [DEST_W-1:0] dest_i,
    output logic [XLEN-1:0]   result_o,
    output logic              wr_en_o,
    output logic [DEST_W-1:0] wr_dest_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic              busy_o
);
    import muldiv_pkg::*;

    localparam int HALF = XLEN / 2;

    op_class_e       cls;
    logic            accept;
    logic            legal;
    logic            is_div;
    logic            is_word;
    logic            want_hi;
    logic            b_zero;
    logic            div_go;
    logic            div_busy;
    logic            div_fin;
    logic [XLEN-1:0] div_res;
    logic [XLEN-1:0] mul_res;

    // Request decode.
    always_comb begin
        cls     = op_class_e'(op_class_i);
        accept  = start_i && !div_busy;
        legal   = (sub_op_i == SUB_LOW) || (sub_op_i == SUB_HIGH);
        is_div  = (cls == CLS_DIV_WORD) || (cls == CLS_DIV_DBL);
        is_word = (cls == CLS_MUL_WORD) || (cls == CLS_DIV_WORD);
        want_hi = (sub_op_i == SUB_HIGH);
        b_zero  = is_word ? (src_b_i[HALF-1:0] == '0) : (src_b_i == '0);
        div_go  = accept && legal && is_div && !b_zero;
    end

    muldiv_mul #(.XLEN(XLEN)) u_mul (
        .is_word_i (is_word),
        .want_hi_i (want_hi),
        .a_i       (src_a_i),
        .b_i       (src_b_i),
        .res_o     (mul_res)
    );

    muldiv_div #(.XLEN(XLEN)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_go),
        .is_word_i  (is_word),
        .want_rem_i (want_hi),
        .a_i        (src_a_i),
        .b_i        (src_b_i),
        .busy_o     (div_busy),
        .fin_o      (div_fin),
        .res_o      (div_res)
    );

    // Output register: completion, write and illegal reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            wr_dest_o <= '0;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
            if (accept) begin
                wr_dest_o <= dest_i;
                if (!legal) begin
                    done_o    <= 1'b1;
                    illegal_o <= 1'b1;
                end else if (!is_div) begin
                    done_o   <= 1'b1;
                    wr_en_o  <= 1'b1;
                    result_o <= mul_res;
                end else if (b_zero) begin
                    done_o <= 1'b1;
                end
            end
            if (div_fin) begin
                done_o   <= 1'b1;
                wr_en_o  <= 1'b1;
                result_o <= div_res;
            end
        end
    end

    assign busy_o = div_busy;
endmodule

// File: rtl/muldiv_unit_sva.sv
// Protocol checker for muldiv_unit, attached by bind below.
// Assumes rst_n is low on the first clock edge.
module muldiv_unit_sva #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [1:0]      op_class_i,
    input logic [4:0]      sub_op_i,
    input logic [XLEN-1:0] src_b_i,
    input logic            wr_en_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic            busy_o
);
    localparam int HALF = XLEN / 2;

    logic legal_sub;
    logic zero_div;
    assign legal_sub = (sub_op_i == 5'd2) || (sub_op_i == 5'd3);
    assign zero_div  = op_class_i[0] ? (src_b_i == '0) : (src_b_i[HALF-1:0] == '0);

    a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && !legal_sub |=> illegal_o && done_o && !wr_en_o);

    a_r8_divzero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && legal_sub && op_class_i[1] && zero_div
        |=> done_o && !wr_en_o && !illegal_o);

    a_r10_mul_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && legal_sub && !op_class_i[1] |=> done_o && wr_en_o);

    a_r10_write_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o);

    a_r11_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    a_r11_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o && wr_en_o);

    a_r12_busy_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !illegal_o);
endmodule

bind muldiv_unit muldiv_unit_sva #(.XLEN(XLEN)) u_sva (.*);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
    localparam int W = 8;
    localparam int H = W / 2;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_class_i = '0;
    logic [4:0]    sub_op_i = '0;
    logic [W-1:0]  src_a_i = '0;
    logic [W-1:0]  src_b_i = '0;
    logic [DW-1:0] dest_i = '0;
    logic [W-1:0]  result_o;
    logic          wr_en_o;
    logic [DW-1:0] wr_dest_o;
    logic          done_o;
    logic          illegal_o;
    logic          busy_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    muldiv_unit #(.XLEN(W), .DEST_W(DW)) uut (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint sxt(input longint v, input int w);
        longint m;
        m = v & ((longint'(1) << w) - 1);
        if (m[w-1]) m = m - (longint'(1) << w);
        return m;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Issue one operation and compare against arithmetic expectations.
    task automatic run_op(input logic [1:0] cls, input logic [4:0] sub,
                          input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [DW-1:0] dst);
        bit     legal, exp_wr, exp_ill, saw_busy;
        int     w, lat, cyc;
        longint x, y, val;
        string  tag, ltag;
        legal = (sub == 5'd2) || (sub == 5'd3);
        w = cls[0] ? W : H;
        x = sxt(longint'(a), w);
        y = sxt(longint'(b), w);
        exp_wr = 1'b0; exp_ill = 1'b0; lat = 1; val = 0;
        ltag = cls[1] ? "R11" : "R10";
        if (!legal) begin
            exp_ill = 1'b1; tag = "R9";
        end else if (!cls[1]) begin
            exp_wr = 1'b1;
            val = (sub == 5'd2) ? sxt(x * y, w) : sxt((x * y) >>> w, w);
            if (!cls[0]) tag = "R3";
            else tag = (sub == 5'd2) ? "R1" : "R2";
        end else if (y == 0) begin
            tag = "R8";
        end else begin
            exp_wr = 1'b1; lat = w + 2;
            val = sxt((sub == 5'd2) ? (x / y) : (x % y), w);
            if (x == -(longint'(1) << (w - 1)) && y == -1) tag = "R7";
            else if (!cls[0]) tag = "R6";
            else tag = (sub == 5'd2) ? "R4" : "R5";
        end
        start_i = 1'b1; op_class_i = cls; sub_op_i = sub;
        src_a_i = a; src_b_i = b; dest_i = dst;
        cyc = 0; saw_busy = 1'b0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
            if (cyc == 1) saw_busy = busy_o;
        end while (!done_o && cyc < 100);
        check(done_o && wr_en_o == exp_wr && illegal_o == exp_ill &&
              (!exp_wr || (result_o == W'(val) && wr_dest_o == dst)),
              tag, longint'({illegal_o, wr_en_o, result_o}),
              longint'({exp_ill, exp_wr, W'(exp_wr ? val : 0)}));
        check(cyc == lat && (lat == 1 || (saw_busy && !busy_o)), ltag,
              longint'(cyc), longint'(lat));
    endtask

    logic [W-1:0] bvals [16] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'hFF, 8'hFE, 8'hFD, 8'd5,
                                 8'd7, 8'hF9, 8'd127, 8'h80, 8'd64, 8'hC0, 8'd13, 8'h9C};

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check(!done_o && !wr_en_o && !illegal_o && !busy_o && result_o == '0,
              "R11 reset", longint'({done_o, wr_en_o, illegal_o, busy_o}), 0);

        // Word multiply and word divide: all low-half pairs, upper halves varied (R3, R6).
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int s = 2; s < 4; s++) begin
                    run_op(2'd0, 5'(s), {4'(i + 5), 4'(i)}, {4'(~j), 4'(j)}, 5'(i));
                    run_op(2'd2, 5'(s), {4'(i * 3), 4'(i)}, {4'(j + 9), 4'(j)}, 5'(j));
                end
            end
        end

        // Doubleword multiply and divide: every dividend against a divisor set (R1, R2, R4, R5, R7, R8).
        for (int i = 0; i < 256; i++) begin
            for (int k = 0; k < 16; k++) begin
                for (int s = 2; s < 4; s++) begin
                    run_op(2'd1, 5'(s), W'(i), bvals[k], 5'(k));
                    run_op(2'd3, 5'(s), W'(i), bvals[k], 5'(k + 16));
                end
            end
        end

        // Illegal sub-operation codes in every class (R9).
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 32; s++) begin
                if (s != 2 && s != 3) run_op(2'(c), 5'(s), 8'h35, 8'h07, 5'd9);
            end
        end

        // Starts while busy are dropped (R12).
        begin
            int  cyc, dones;
            bit  ill_seen;
            start_i = 1'b1; op_class_i = 2'd3; sub_op_i = 5'd2;
            src_a_i = 8'd100; src_b_i = 8'd7; dest_i = 5'd21;
            @(negedge clk);
            cyc = 1; dones = 0; ill_seen = 1'b0;
            op_class_i = 2'd1; sub_op_i = 5'd9; src_a_i = 8'h11; dest_i = 5'd4;
            repeat (3) begin
                @(negedge clk);
                cyc++;
                if (done_o) dones++;
                if (illegal_o) ill_seen = 1'b1;
            end
            start_i = 1'b0;
            while (!done_o && cyc < 60) begin
                @(negedge clk);
                cyc++;
                if (illegal_o) ill_seen = 1'b1;
            end
            dones++;
            check(wr_en_o && result_o == 8'd14 && wr_dest_o == 5'd21 && !ill_seen,
                  "R12 result", longint'({wr_dest_o, result_o}), longint'({5'd21, 8'd14}));
            check(cyc == W + 2, "R12 timing", longint'(cyc), longint'(W + 2));
            @(negedge clk);
            if (done_o) dones++;
            check(dones == 1, "R12 done count", longint'(dones), 1);
        end

        summary();
        $finish;
    end
endmodule